// File: doc/BRIEF.md
# Quad-Lane Transmit Character Capture

This block takes in four character lanes on the transmit side. Each lane supplies a byte, two control bits and an odd-parity bit. One select bit is shared by all lanes and marks special characters. The block registers each lane and then hands a tagged word per lane to a downstream encoder or alignment stage, together with a single valid strobe for all lanes. A two-bit mode input sets how each word is read downstream. In bypass mode the byte and control bits together are one pre-encoded 10-bit character. In the two encoded modes the control bits qualify the byte. In three-bit control mode the shared select bit acts as the third control bit.

The lanes can be written in one of two ways. In common mode, lane A's write strobe captures all four lanes together and the result appears after a short fixed latency. In independent mode, each lane captures on its own strobe and its characters queue in a small per-lane buffer. A word set is released only when every lane holds a character. The select bit is sampled with lane A's writes and travels beside lane A's character, so the n-th character of every lane comes out together and carries the select value taken with lane A's n-th character. A parity checker flags bad lanes on the output word they belong to.

Top module: `txcap_quad`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `out_valid`, `par_err` and `out_word` are all zero.
- R2: In common mode (`indep` = 0), bit 0 of `lane_wr` alone captures all four lanes and the other bits have no effect. Inputs sampled at clock edge k produce `out_valid` high after edge k+1, for exactly one cycle per capture.
- R3: Lane i's word sits at `out_word[11*i +: 11]`, with the byte in bits 7:0, the control pair in bits 9:8 and the select flag in bit 10. In bypass mode, bits 9:0 form the pre-encoded character: bit 0 of the byte is the LSB and control bit 1 is the MSB.
- R4: Mode encoding: `mode[1]` = 1 is bypass, 2'b00 is encoded with two control bits, and 2'b01 is encoded with three control bits. The select input is captured only in 2'b01. In every other mode the output select flag is 0 whatever `sel_in` holds.
- R5: In common mode the select value taken with a capture appears in bit 10 of all four lane words of that capture, and it may differ on every capture.
- R6: In independent mode (`indep` = 1), lane i captures on `lane_wr[i]` and keeps its characters in order. `out_valid` rises only when every lane holds a character, and the n-th output carries the n-th character of each lane.
- R7: In independent mode the select bit is sampled when lane A (`lane_wr[0]`) writes, and all four words of the output that holds lane A's matching character carry it.
- R8: With `par_chk_en` high at capture, a lane whose byte and parity bit together hold an even number of ones raises its `par_err` bit only in the cycle its word is presented with `out_valid`. `par_err` is never high without `out_valid`.
- R9: With `par_chk_en` low at capture, `par_err` stays low for that character whatever its parity.
- R10: While `indep` is low the per-lane buffers are emptied. Characters still waiting when the block leaves independent mode never reach the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| indep | input | 1 | 1: each lane captures on its own strobe; 0: lane A's strobe captures all lanes |
| mode | input | 2 | Lane treatment: 2'b00 two-bit control, 2'b01 three-bit control, 2'b1x bypass |
| par_chk_en | input | 1 | Enables the odd-parity check for characters captured in that cycle |
| sel_in | input | 1 | Shared special-character select bit |
| lane_wr | input | LANES | Per-lane capture strobes |
| lane_dat | input | LANES*8 | Lane bytes, lane i at bits 8*i+7:8*i |
| lane_ctl | input | LANES*2 | Lane control pairs, lane i at bits 2*i+1:2*i |
| lane_par | input | LANES | Lane odd-parity bits |
| out_valid | output | 1 | One aligned word set is presented this cycle |
| out_word | output | LANES*11 | Per-lane tagged words {select, control, byte} |
| par_err | output | LANES | Per-lane parity error, valid with `out_valid` |

## Verification
The assertions assume that `indep` changes only while no character is in flight. They also assume that in independent mode no lane gets more characters ahead of the slowest lane than the buffer depth can absorb, and that inputs stay at zero during reset. The stimulus leaves several idle cycles around every switch of `indep`. In independent mode it lets a lane write only while it is fewer than two characters ahead of the slowest lane, which keeps every buffer below full. Before the independent phase ends, it tops up the lagging lanes so the bench's expectation queues drain to empty.

// File: rtl/txcap_pkg.sv
package txcap_pkg;
   localparam int BYTE_W = 8;
   localparam int CTL_W  = 2;
   localparam int WORD_W = BYTE_W + CTL_W + 1;

   typedef enum logic [1:0] {
      CM_ENC2    = 2'b00,
      CM_ENC3    = 2'b01,
      CM_RAW     = 2'b10,
      CM_RAW_ALT = 2'b11
   } cap_mode_e;

   typedef struct packed {
      logic              perr;
      logic [CTL_W-1:0]  ctl;
      logic [BYTE_W-1:0] dat;
   } lane_ent_t;

   localparam int ENT_W = $bits(lane_ent_t);
endpackage

// File: rtl/txcap_lane.sv
module txcap_lane
   import txcap_pkg::*;
#(
   parameter bit ODD_PAR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              chk_en,
   input  logic [BYTE_W-1:0] dat,
   input  logic [CTL_W-1:0]  ctl,
   input  logic              par,
   output logic              cap_v,
   output lane_ent_t         cap_ent
);
   logic par_bad;

   generate
      if (ODD_PAR) begin : g_odd
         assign par_bad = ~(^{dat, par});
      end else begin : g_even
         assign par_bad = ^{dat, par};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_v   <= 1'b0;
         cap_ent <= '0;
      end else begin
         cap_v <= wr;
         if (wr) begin
            cap_ent.dat  <= dat;
            cap_ent.ctl  <= ctl;
            cap_ent.perr <= chk_en & par_bad;
         end
      end
   end
endmodule

// File: rtl/txcap_fifo.sv
module txcap_fifo #(
   parameter int W     = 11,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("txcap_fifo: DEPTH must be a power of two, at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("txcap_fifo: W must be positive");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;

   assign empty = (wp == rp);
   assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign dout  = mem[rp[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push && !full && !flush) begin
         mem[wp[AW-1:0]] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else if (flush) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push && !full) wp <= wp + 1'b1;
         if (pop && !empty) rp <= rp + 1'b1;
      end
   end
endmodule

// File: rtl/txcap_quad.sv
module txcap_quad
   import txcap_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int FIFO_DEPTH = 4,
   parameter bit ODD_PAR    = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      indep,
   input  logic [1:0]                mode,
   input  logic                      par_chk_en,
   input  logic                      sel_in,
   input  logic [LANES-1:0]          lane_wr,
   input  logic [LANES*BYTE_W-1:0]   lane_dat,
   input  logic [LANES*CTL_W-1:0]    lane_ctl,
   input  logic [LANES-1:0]          lane_par,
   output logic                      out_valid,
   output logic [LANES*WORD_W-1:0]   out_word,
   output logic [LANES-1:0]          par_err
);
   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("txcap_quad: LANES must be at least 1");
      end
   endgenerate

   cap_mode_e        mode_e;
   logic [LANES-1:0] wr_eff;
   logic [LANES-1:0] cap_v;
   lane_ent_t        cap_ent  [LANES];
   lane_ent_t        head_ent [LANES];
   lane_ent_t        src_ent  [LANES];
   logic             cap_sel;
   logic             head_sel;
   logic             src_sel;
   logic [LANES-1:0] fifo_push;
   logic [LANES-1:0] fifo_full;
   logic [LANES-1:0] fifo_empty;
   logic             all_ready;
   logic             fifo_pop;
   logic             emit;

   assign mode_e = cap_mode_e'(mode);
   assign wr_eff = indep ? lane_wr : {LANES{lane_wr[0]}};

   // shared select: taken only with lane A's write, only in three-bit control mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_sel <= 1'b0;
      end else if (wr_eff[0]) begin
         cap_sel <= (mode_e == CM_ENC3) & sel_in;
      end
   end

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         txcap_lane #(.ODD_PAR(ODD_PAR)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (wr_eff[i]),
            .chk_en (par_chk_en),
            .dat    (lane_dat[i*BYTE_W +: BYTE_W]),
            .ctl    (lane_ctl[i*CTL_W +: CTL_W]),
            .par    (lane_par[i]),
            .cap_v  (cap_v[i]),
            .cap_ent(cap_ent[i])
         );

         assign fifo_push[i] = cap_v[i] & indep;

         if (i == 0) begin : g_lead
            // lane A's buffer also carries the select bit
            logic [ENT_W:0] lead_head;
            txcap_fifo #(.W(ENT_W + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
               .clk  (clk),
               .rst_n(rst_n),
               .flush(~indep),
               .push (fifo_push[i]),
               .din  ({cap_sel, cap_ent[i]}),
               .pop  (fifo_pop),
               .dout (lead_head),
               .empty(fifo_empty[i]),
               .full (fifo_full[i])
            );
            assign head_sel    = lead_head[ENT_W];
            assign head_ent[i] = lane_ent_t'(lead_head[ENT_W-1:0]);
         end else begin : g_follow
            logic [ENT_W-1:0] fol_head;
            txcap_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
               .clk  (clk),
               .rst_n(rst_n),
               .flush(~indep),
               .push (fifo_push[i]),
               .din  (cap_ent[i]),
               .pop  (fifo_pop),
               .dout (fol_head),
               .empty(fifo_empty[i]),
               .full (fifo_full[i])
            );
            assign head_ent[i] = lane_ent_t'(fol_head);
         end

         assign src_ent[i] = indep ? head_ent[i] : cap_ent[i];
      end
   endgenerate

   assign all_ready = ~|fifo_empty;
   assign fifo_pop  = indep & all_ready;
   assign emit      = indep ? all_ready : cap_v[0];
   assign src_sel   = indep ? head_sel : cap_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         par_err   <= '0;
         out_word  <= '0;
      end else begin
         out_valid <= emit;
         for (int i = 0; i < LANES; i++) begin
            par_err[i] <= emit & src_ent[i].perr;
            if (emit) begin
               out_word[i*WORD_W +: WORD_W] <= {src_sel, src_ent[i].ctl, src_ent[i].dat};
            end
         end
      end
   end
endmodule

// File: rtl/txcap_quad_chk.sv
module txcap_quad_chk
   import txcap_pkg::*;
#(
   parameter int LANES = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    indep,
   input logic [1:0]              mode,
   input logic                    par_chk_en,
   input logic [LANES-1:0]        lane_wr,
   input logic                    out_valid,
   input logic [LANES*WORD_W-1:0] out_word,
   input logic [LANES-1:0]        par_err,
   input logic [LANES-1:0]        fifo_push,
   input logic [LANES-1:0]        fifo_full,
   input logic [LANES-1:0]        fifo_empty
);
   logic [1:0]       age;
   logic [LANES-1:0] sel_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   always_comb begin
      for (int i = 0; i < LANES; i++) sel_vec[i] = out_word[i*WORD_W + WORD_W - 1];
   end

   p_common_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && !indep && !$past(indep) && !$past(indep, 2))
         |-> (out_valid == $past(lane_wr[0], 2)));

   p_sel_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && !indep && !$past(indep) && !$past(indep, 2)
       && $past(lane_wr[0], 2) && ($past(mode, 2) != 2'b01))
         |-> (sel_vec == '0));

   p_sel_shared_r5_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (sel_vec == '0 || sel_vec == '1));

   p_err_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (par_err != '0) |-> out_valid);

   p_check_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && !indep && !$past(indep) && !$past(indep, 2) && !$past(par_chk_en, 2))
         |-> (par_err == '0));

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((fifo_push & fifo_full) == '0));

   p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd1 && !$past(indep)) |-> (fifo_empty == '1));
endmodule

bind txcap_quad txcap_quad_chk #(.LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .indep     (indep),
   .mode      (mode),
   .par_chk_en(par_chk_en),
   .lane_wr   (lane_wr),
   .out_valid (out_valid),
   .out_word  (out_word),
   .par_err   (par_err),
   .fifo_push (fifo_push),
   .fifo_full (fifo_full),
   .fifo_empty(fifo_empty)
);

// File: tb/sim_txcap_quad.sv
module sim_txcap_quad;
   localparam int LANES      = 4;
   localparam int DEPTH      = 4;
   localparam int CLK_PERIOD = 10;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 indep = 1'b0;
   logic [1:0]           mode = 2'b00;
   logic                 par_chk_en = 1'b0;
   logic                 sel_in = 1'b0;
   logic [LANES-1:0]     lane_wr = '0;
   logic [LANES*8-1:0]   lane_dat = '0;
   logic [LANES*2-1:0]   lane_ctl = '0;
   logic [LANES-1:0]     lane_par = '0;
   logic                 out_valid;
   logic [LANES*11-1:0]  out_word;
   logic [LANES-1:0]     par_err;

   txcap_quad #(.LANES(LANES), .FIFO_DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .indep(indep), .mode(mode), .par_chk_en(par_chk_en),
      .sel_in(sel_in), .lane_wr(lane_wr), .lane_dat(lane_dat), .lane_ctl(lane_ctl),
      .lane_par(lane_par), .out_valid(out_valid), .out_word(out_word), .par_err(par_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;
   logic [10:0] exq [LANES][$];
   bit    selq [$];
   bit    wr0_h1 = 1'b0, wr0_h2 = 1'b0;
   string tag  = "R3";
   string ptag = "R8";
   int    cnt [LANES];

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp,
                        input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit exp_sel(input logic [1:0] md, input bit s);
      return (md == 2'b01) && s;
   endfunction

   task automatic sample();
      if (!indep) check("R2", 64'(out_valid), 64'(wr0_h2), "out_valid latency");
      if (out_valid) begin
         bit ok = (selq.size() != 0);
         for (int i = 0; i < LANES; i++) if (exq[i].size() == 0) ok = 1'b0;
         if (!ok) begin
            check(tag, 64'(1), 64'(0), "out_valid with no pending character");
         end else begin
            bit s = selq.pop_front();
            for (int i = 0; i < LANES; i++) begin
               logic [10:0] e = exq[i].pop_front();
               check(tag, 64'(out_word[i*11 +: 11]), 64'({s, e[9:0]}), "lane word");
               check(ptag, 64'(par_err[i]), 64'(e[10]), "par_err");
            end
         end
      end else begin
         check("R8", 64'(par_err), 64'(0), "par_err without out_valid");
      end
   endtask

   task automatic drive(input logic [LANES-1:0] wr, input logic [1:0] md, input bit s,
                        input bit chk, input logic [LANES-1:0] bad);
      sample();
      wr0_h2 = wr0_h1;
      wr0_h1 = indep ? 1'b0 : wr[0];
      mode = md; sel_in = s; par_chk_en = chk; lane_wr = wr;
      for (int i = 0; i < LANES; i++) begin
         logic [7:0] d = 8'($urandom);
         logic [1:0] c = 2'($urandom);
         logic       p = ~(^d) ^ bad[i];
         bit take = indep ? wr[i] : wr[0];
         lane_dat[i*8 +: 8] = d;
         lane_ctl[i*2 +: 2] = c;
         lane_par[i]        = p;
         if (take) begin
            exq[i].push_back({chk & bad[i], c, d});
            cnt[i]++;
         end
      end
      if (wr[0]) selq.push_back(exp_sel(md, s));
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) drive('0, 2'b00, 1'b0, 1'b0, '0);
   endtask

   task automatic clear_model();
      for (int i = 0; i < LANES; i++) begin
         exq[i].delete();
         cnt[i] = 0;
      end
      selq.delete();
   endtask

   task automatic check_drained(input string req);
      check(req, 64'(selq.size()), 64'(0), "select queue drained");
      for (int i = 0; i < LANES; i++) check(req, 64'(exq[i].size()), 64'(0), "lane queue drained");
   endtask

   initial begin
      void'($urandom(32'h5EED_0401));
      for (int i = 0; i < LANES; i++) cnt[i] = 0;
      repeat (3) @(negedge clk);
      // R1: outputs held low during reset
      check("R1", 64'(out_valid), 64'(0), "out_valid in reset");
      check("R1", 64'(out_word), 64'(0), "out_word in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 64'(out_valid), 64'(0), "out_valid after reset");
      check("R1", 64'(par_err), 64'(0), "par_err after reset");

      // R4: select honoured only in three-bit control mode
      tag = "R4";
      drive(4'b0001, 2'b10, 1'b1, 1'b1, '0);
      drive(4'b1111, 2'b00, 1'b1, 1'b1, '0);
      drive(4'b0001, 2'b11, 1'b1, 1'b1, '0);
      drive(4'b0001, 2'b01, 1'b1, 1'b1, '0);
      idle(3);

      // R5: select toggles capture by capture
      tag = "R5";
      for (int k = 0; k < 6; k++) drive(4'b0001, 2'b01, k[0], 1'b1, '0);
      // R2: other strobe bits alone capture nothing
      tag = "R2";
      drive(4'b1110, 2'b01, 1'b1, 1'b1, '0);
      drive(4'b0110, 2'b00, 1'b0, 1'b1, '0);
      idle(3);

      // R9: parity check off, every lane bad
      tag = "R3"; ptag = "R9";
      for (int k = 0; k < 5; k++) drive(4'b0001, 2'($urandom), 1'($urandom), 1'b0, '1);
      // R8: parity check on, every lane bad
      ptag = "R8";
      for (int k = 0; k < 3; k++) drive(4'b0001, 2'b00, 1'b0, 1'b1, '1);
      idle(3);

      // common-mode random traffic
      tag = "R3";
      for (int k = 0; k < 300; k++) begin
         logic [LANES-1:0] bad = '0;
         for (int i = 0; i < LANES; i++) bad[i] = ($urandom % 5) == 0;
         drive(LANES'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), bad);
      end
      idle(4);
      check_drained("R2");

      // independent mode
      clear_model();
      indep = 1'b1;
      idle(2);

      // R7: lane A leads with two characters carrying different selects
      tag = "R7";
      drive(4'b0001, 2'b01, 1'b1, 1'b1, '0);
      drive(4'b0001, 2'b01, 1'b0, 1'b1, '0);
      drive(4'b1110, 2'b01, 1'b1, 1'b1, '0);
      drive(4'b1110, 2'b00, 1'b1, 1'b1, '0);
      idle(4);
      check_drained("R7");

      // R6: random per-lane strobes with skew kept under two characters
      tag = "R6";
      for (int k = 0; k < 400; k++) begin
         logic [LANES-1:0] w = '0;
         logic [LANES-1:0] bad = '0;
         int mn = cnt[0];
         for (int i = 1; i < LANES; i++) if (cnt[i] < mn) mn = cnt[i];
         for (int i = 0; i < LANES; i++) begin
            w[i]   = (cnt[i] < mn + 2) && ($urandom % 2 == 0);
            bad[i] = ($urandom % 5) == 0;
         end
         drive(w, 2'($urandom), 1'($urandom), 1'($urandom), bad);
      end
      for (int k = 0; k < 8; k++) begin
         logic [LANES-1:0] w = '0;
         int mx = cnt[0];
         for (int i = 1; i < LANES; i++) if (cnt[i] > mx) mx = cnt[i];
         for (int i = 0; i < LANES; i++) w[i] = cnt[i] < mx;
         drive(w, 2'($urandom), 1'($urandom), 1'b1, '0);
      end
      idle(4);
      check_drained("R6");

      // R10: characters stranded in a buffer are dropped when leaving independent mode
      tag = "R10";
      drive(4'b0010, 2'b00, 1'b0, 1'b1, '0);
      drive(4'b0010, 2'b00, 1'b0, 1'b1, '0);
      idle(3);
      clear_model();
      indep = 1'b0;
      idle(3);
      indep = 1'b1;
      idle(2);
      drive(4'b1111, 2'b01, 1'b1, 1'b1, '0);
      idle(4);
      check_drained("R10");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule